// File: doc/BRIEF.md
# Card-Side Asynchronous Bus Target with Byte-Lane Steering

This block is the slave logic on a removable card that sits on a 16-bit asynchronous card bus. The host raises a cycle by pulling one or both chip enables low and then strobing an output-enable or write-enable line (memory and attribute spaces) or a separate pair of I/O read/write strobes (I/O space). The block brings every bus control line into its own clock domain and finds out which of three address spaces is targeted. It then runs one access against a small internal register file of 16-bit words with per-byte write enables.

The block holds the bus wait line low for a programmable number of internal clocks, so the host stretches the cycle until the internal side has finished. Byte lanes are steered by the two enables and the lowest address bit. The low enable alone carries a byte on the low data half, even or odd as the address selects. The high enable alone carries the odd byte on the high half. Both enables together carry a full word. The external data bus is split into input, output and per-lane output-enable signals so that the pad ring can build the three-state drivers. A card reset input puts the attribute (configuration) words back to their default values.

Top module: `pcc_target`

## Requirements
- R1: After `rst` is released, `wait_n` is 1, `dq_oe` is 2'b00, and every attribute word at index i reads 16'hA500 | i. Every common and I/O word reads 16'h0000.
- R2: An access starts only when a strobe falls while at least one of `ce1_n`/`ce2_n` is low. A strobe with both enables high leaves `wait_n` at 1 and writes nothing.
- R3: A strobe driven low between clock edges makes `wait_n` go low after the third following rising edge. It stays low for exactly LATENCY cycles and then returns to 1. This is the same in all three spaces.
- R4: `oe_n`/`we_n` with `reg_n`=1 select common memory, and with `reg_n`=0 they select attribute memory. `iord_n`/`iowr_n` with `reg_n`=0 select I/O space. An I/O strobe with `reg_n`=1 is ignored.
- R5: With both enables low, the full 16-bit word moves on dq[15:0], and `dq_oe` is 2'b11 on a read.
- R6: With only `ce1_n` low, a byte moves on dq[7:0]: `addr[0]`=0 selects the low byte of the word and `addr[0]`=1 the high byte. On a read `dq_oe` is 2'b01.
- R7: With only `ce2_n` low, the high (odd) byte of the word moves on dq[15:8]. On a read `dq_oe` is 2'b10.
- R8: A byte write changes only the internal byte that R6/R7 select, and the other byte of the word keeps its value.
- R9: The word index is `addr[IDX_W:1]`. Address bits above it, up to `addr[25]`, are ignored, so such addresses alias.
- R10: An output-enable bit is 1 only while a read strobe and the matching enable are both low. It drops without any clock once the enables go high.
- R11: While the card reset input is high (after synchronisation), the attribute words return to 16'hA500 | i. Common-memory contents are unchanged.
- R12: A strobe that falls while an access is already in progress starts no second access and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high internal reset |
| card_reset | input | 1 | Asynchronous card reset from the bus, active high |
| ce1_n | input | 1 | Low-byte chip enable, active low |
| ce2_n | input | 1 | High-byte chip enable, active low |
| reg_n | input | 1 | Attribute/I/O space select, active low |
| oe_n | input | 1 | Memory read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| addr | input | 26 | Bus address, bit 25 most significant |
| dq_i | input | 16 | Data from the bus pads |
| dq_o | output | 16 | Data to the bus pads |
| dq_oe | output | 2 | Per-lane output enable: bit 0 for dq[7:0], bit 1 for dq[15:8] |
| wait_n | output | 1 | Cycle-stretch request to the host, active low |

## Verification
The bench builds the block with IDX_W = 3 and LATENCY = 4. Eight words per space make aliasing reachable with a single high address bit set, and it also lets A25 be exercised. The four-cycle wait window is long enough for a second strobe to pass through the whole synchroniser and edge detector while the first access is still busy, which tests that the second strobe is dropped. The behavioural model predicts the exact clock in which `wait_n` falls and rises for each access and checks it on every cycle.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        SP_COMMON = 2'd0,
        SP_ATTR   = 2'd1,
        SP_IO     = 2'd2
    } space_e;

    typedef enum logic [1:0] {
        LM_WORD    = 2'd0,
        LM_LO_EVEN = 2'd1,
        LM_LO_ODD  = 2'd2,
        LM_HI_ODD  = 2'd3
    } lane_e;

    typedef struct packed {
        logic   wr;
        space_e space;
        lane_e  mode;
    } req_t;

    function automatic lane_e lane_mode(input logic ce1_n, input logic ce2_n, input logic a0);
        if (!ce1_n && !ce2_n) return LM_WORD;
        if (!ce1_n)           return a0 ? LM_LO_ODD : LM_LO_EVEN;
        return LM_HI_ODD;
    endfunction

    function automatic logic [1:0] lane_be(input lane_e m);
        case (m)
            LM_WORD:    return 2'b11;
            LM_LO_EVEN: return 2'b01;
            default:    return 2'b10;
        endcase
    endfunction

    // bus data -> internal word alignment
    function automatic logic [DATA_W-1:0] to_internal(input lane_e m, input logic [DATA_W-1:0] bus);
        case (m)
            LM_WORD:    return bus;
            LM_LO_EVEN: return {8'h00, bus[7:0]};
            LM_LO_ODD:  return {bus[7:0], 8'h00};
            default:    return {bus[15:8], 8'h00};
        endcase
    endfunction

    // internal word -> bus lane alignment
    function automatic logic [DATA_W-1:0] to_bus(input lane_e m, input logic [DATA_W-1:0] word);
        case (m)
            LM_WORD:    return word;
            LM_LO_EVEN: return {8'h00, word[7:0]};
            LM_LO_ODD:  return {8'h00, word[15:8]};
            default:    return {word[15:8], 8'h00};
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] attr_default(input logic [7:0] idx);
        return 16'hA500 | {8'h00, idx};
    endfunction

endpackage

// File: rtl/pcc_sync.sv
module pcc_sync #(
    parameter int            WIDTH = 8,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= INIT;
            stage2 <= INIT;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
    import pcc_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              crst_s,
    input  logic              ce1_s,
    input  logic              ce2_s,
    input  logic              reg_s,
    input  logic              oe_s,
    input  logic              we_s,
    input  logic              iord_s,
    input  logic              iowr_s,
    input  logic              a0,
    input  logic [IDX_W-1:0]  addr_idx,
    input  logic [DATA_W-1:0] dq_i,
    input  logic [DATA_W-1:0] rdata,
    output logic              go,
    output req_t              req,
    output logic [IDX_W-1:0]  idx_q,
    output logic [1:0]        be,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_bus,
    output logic              wait_n
);
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    logic [3:0] strb_prev;   // {iowr, iord, we, oe}
    logic [3:0] strb_cur;
    logic [3:0] strb_fall;
    logic       busy;
    logic [CNT_W-1:0] cnt;
    logic       start, st_wr, any_ce;
    space_e     st_sp;

    assign strb_cur  = {iowr_s, iord_s, we_s, oe_s};
    assign strb_fall = strb_prev & ~strb_cur;
    assign any_ce    = !ce1_s || !ce2_s;

    always_ff @(posedge clk) begin
        if (rst) strb_prev <= 4'hF;
        else     strb_prev <= strb_cur;
    end

    // decode of a fresh access; write strobes win over read strobes
    always_comb begin
        start = 1'b0;
        st_wr = 1'b0;
        st_sp = SP_COMMON;
        if (!busy && !crst_s && any_ce) begin
            if (strb_fall[1]) begin
                start = 1'b1; st_wr = 1'b1; st_sp = reg_s ? SP_COMMON : SP_ATTR;
            end else if (strb_fall[0]) begin
                start = 1'b1; st_sp = reg_s ? SP_COMMON : SP_ATTR;
            end else if (!reg_s && strb_fall[3]) begin
                start = 1'b1; st_wr = 1'b1; st_sp = SP_IO;
            end else if (!reg_s && strb_fall[2]) begin
                start = 1'b1; st_sp = SP_IO;
            end
        end
    end

    assign go = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            wait_n <= 1'b1;
            cnt    <= '0;
            req    <= '{wr: 1'b0, space: SP_COMMON, mode: LM_WORD};
            idx_q  <= '0;
            rd_bus <= '0;
        end else if (crst_s) begin
            busy   <= 1'b0;
            wait_n <= 1'b1;
            cnt    <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            wait_n <= 1'b0;
            cnt    <= CNT_W'(LATENCY - 1);
            req    <= '{wr: st_wr, space: st_sp, mode: lane_mode(ce1_s, ce2_s, a0)};
            idx_q  <= addr_idx;
        end else if (busy) begin
            if (cnt == '0) begin
                busy   <= 1'b0;
                wait_n <= 1'b1;
                if (!req.wr) rd_bus <= to_bus(req.mode, rdata);
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign be    = lane_be(req.mode);
    assign wdata = to_internal(req.mode, dq_i);

    // R3: the completing cycle always releases wait and frees the engine
    p_release_r3: assert property (@(posedge clk) disable iff (rst || crst_s)
        go |=> (wait_n && !busy));

    // R3: wait is never held while no access is in flight
    p_idle_wait_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> wait_n);

    // R8: a completing access always enables at least one byte
    p_be_live_r8: assert property (@(posedge clk) disable iff (rst)
        go |-> (be != 2'b00));

    // R12: an access in flight keeps its decode, whatever the strobes do
    p_hold_req_r12: assert property (@(posedge clk) disable iff (rst || crst_s)
        (busy && !go) |=> ($stable(req) && $stable(idx_q)));
endmodule

// File: rtl/pcc_regfile.sv
module pcc_regfile
    import pcc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              crst_s,
    input  logic              go,
    input  logic              wr,
    input  space_e            space,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int NBANK = 3;

    logic [DATA_W-1:0] bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam bit IS_ATTR = (b == 1);
        logic [DATA_W-1:0] mem [DEPTH];
        logic sel;

        assign sel = go && wr && (int'(space) == b);

        always_ff @(posedge clk) begin
            if (rst || (IS_ATTR && crst_s)) begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] <= IS_ATTR ? attr_default(8'(i)) : '0;
            end else if (sel) begin
                if (be[0]) mem[idx][7:0]  <= wdata[7:0];
                if (be[1]) mem[idx][15:8] <= wdata[15:8];
            end
        end

        assign bank_rd[b] = mem[idx];

        if (IS_ATTR) begin : g_chk
            // R11: card reset leaves the configuration words at their defaults
            p_attr_dflt_r11: assert property (@(posedge clk) disable iff (rst)
                crst_s |=> (mem[0] == attr_default(8'd0) &&
                            mem[DEPTH-1] == attr_default(8'(DEPTH-1))));
        end
    end

    always_comb begin
        case (space)
            SP_ATTR: rdata = bank_rd[1];
            SP_IO:   rdata = bank_rd[2];
            default: rdata = bank_rd[0];
        endcase
    end
endmodule

// File: rtl/pcc_target.sv
module pcc_target
    import pcc_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int LATENCY = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        card_reset,
    input  logic        ce1_n,
    input  logic        ce2_n,
    input  logic        reg_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        iord_n,
    input  logic        iowr_n,
    input  logic [25:0] addr,
    input  logic [15:0] dq_i,
    output logic [15:0] dq_o,
    output logic [1:0]  dq_oe,
    output logic        wait_n
);
    logic [7:0] raw_ctl, sync_ctl;
    logic       go;
    req_t       req;
    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        be;
    logic [DATA_W-1:0] wdata, rdata, rd_bus;
    logic              rd_strobe;
    logic              unused_addr;

    assign raw_ctl = {card_reset, iowr_n, iord_n, we_n, oe_n, reg_n, ce2_n, ce1_n};

    pcc_sync #(.WIDTH(8), .INIT(8'b0111_1111)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_ctl),
        .q   (sync_ctl)
    );

    pcc_ctrl #(.IDX_W(IDX_W), .LATENCY(LATENCY)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .crst_s   (sync_ctl[7]),
        .ce1_s    (sync_ctl[0]),
        .ce2_s    (sync_ctl[1]),
        .reg_s    (sync_ctl[2]),
        .oe_s     (sync_ctl[3]),
        .we_s     (sync_ctl[4]),
        .iord_s   (sync_ctl[5]),
        .iowr_s   (sync_ctl[6]),
        .a0       (addr[0]),
        .addr_idx (addr[IDX_W:1]),
        .dq_i     (dq_i),
        .rdata    (rdata),
        .go       (go),
        .req      (req),
        .idx_q    (idx_q),
        .be       (be),
        .wdata    (wdata),
        .rd_bus   (rd_bus),
        .wait_n   (wait_n)
    );

    pcc_regfile #(.IDX_W(IDX_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .crst_s (sync_ctl[7]),
        .go     (go),
        .wr     (req.wr),
        .space  (req.space),
        .idx    (idx_q),
        .be     (be),
        .wdata  (wdata),
        .rdata  (rdata)
    );

    // lanes follow the live pins so the bus is freed as soon as enables rise
    assign rd_strobe = !oe_n || !iord_n;
    assign dq_oe     = {rd_strobe && !ce2_n, rd_strobe && !ce1_n};
    assign dq_o      = rd_bus;

    assign unused_addr = ^addr[25:IDX_W+1];
endmodule

// File: tb/pcc_target_tb_top.sv
module pcc_target_tb_top;
    localparam int IDX_W = 3;
    localparam int LAT   = 4;
    localparam int DEPTH = 1 << IDX_W;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, card_reset = 1'b0;
    logic ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1;
    logic oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
    logic [25:0] addr = '0;
    logic [15:0] dq_i = '0;
    logic [15:0] dq_o;
    logic [1:0]  dq_oe;
    logic        wait_n;

    pcc_target #(.IDX_W(IDX_W), .LATENCY(LAT)) dut_i (
        .clk(clk), .rst(rst), .card_reset(card_reset),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n),
        .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
        .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .wait_n(wait_n)
    );

    int   n_chk = 0, n_fail = 0;
    bit   cmp_en = 1'b0, done = 1'b0;
    logic exp_wait = 1'b1;
    logic [15:0] m_com [DEPTH];
    logic [15:0] m_att [DEPTH];
    logic [15:0] m_io  [DEPTH];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // every-cycle comparison of the stretch line against the model (R3)
    always @(negedge clk) if (cmp_en) check(wait_n === exp_wait, "R3 wait_n per cycle", 32'(wait_n), 32'(exp_wait));

    function automatic logic [15:0] mget(input int sp, input int i);
        if (sp == 0) return m_com[i];
        if (sp == 1) return m_att[i];
        return m_io[i];
    endfunction

    task automatic mput(input int sp, input int i, input logic [15:0] v);
        if (sp == 0) m_com[i] = v;
        else if (sp == 1) m_att[i] = v;
        else m_io[i] = v;
    endtask

    // sp: 0 common, 1 attribute, 2 I/O, 3 I/O strobe with reg_n high
    task automatic bus_cycle(input int sp, input bit c1, input bit c2, input logic [25:0] a,
                             input bit wr, input logic [15:0] wd, input bit go_exp,
                             input bit inject, input string tag);
        int idx;
        logic [15:0] m;
        logic [1:0]  e_oe;
        idx = int'(a[IDX_W:1]);
        @(negedge clk);
        addr = a; ce1_n = !c1; ce2_n = !c2; reg_n = (sp == 0 || sp == 3); dq_i = wd;
        @(negedge clk);
        if (sp >= 2) begin if (wr) iowr_n = 1'b0; else iord_n = 1'b0; end
        else begin if (wr) we_n = 1'b0; else oe_n = 1'b0; end
        repeat (3) @(posedge clk);
        #1 if (go_exp) exp_wait = 1'b0;
        if (inject) begin @(negedge clk); we_n = 1'b0; end
        if (go_exp) begin
            repeat (LAT) @(posedge clk);
            #1 exp_wait = 1'b1;
        end
        m = mget(sp, idx);
        if (go_exp && wr) begin
            if (c1 && c2) m = wd;
            else if (c1 && !a[0]) m[7:0] = wd[7:0];
            else if (c1) m[15:8] = wd[7:0];
            else m[15:8] = wd[15:8];
            mput(sp, idx, m);
        end
        @(negedge clk);
        if (go_exp && !wr) begin
            e_oe = {c2, c1};
            check(dq_oe == e_oe, tag, 32'(dq_oe), 32'(e_oe));
            if (c1 && c2)     check(dq_o == m, tag, 32'(dq_o), 32'(m));
            else if (c1)      check(dq_o[7:0] == (a[0] ? m[15:8] : m[7:0]), tag,
                                    32'(dq_o[7:0]), 32'(a[0] ? m[15:8] : m[7:0]));
            else              check(dq_o[15:8] == m[15:8], tag, 32'(dq_o[15:8]), 32'(m[15:8]));
        end
        ce1_n = 1'b1; ce2_n = 1'b1;
        #1;
        if (!wr) check(dq_oe == 2'b00, "R10 lanes released with enables high", 32'(dq_oe), 32'd0);
        @(negedge clk);
        oe_n = 1'b1; we_n = 1'b1; iord_n = 1'b1; iowr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_com[i] = 16'h0000;
            m_io[i]  = 16'h0000;
            m_att[i] = 16'hA500 | 16'(i);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp_en = 1'b1;
        check(wait_n == 1'b1, "R1 wait_n after reset", 32'(wait_n), 32'd1);
        check(dq_oe == 2'b00, "R1 lanes idle after reset", 32'(dq_oe), 32'd0);

        bus_cycle(1, 1, 1, 26'h0, 0, 16'h0, 1, 0, "R1 attribute default idx0");
        bus_cycle(1, 1, 1, 26'hE, 0, 16'h0, 1, 0, "R1 attribute default idx7");
        bus_cycle(0, 1, 1, 26'h6, 0, 16'h0, 1, 0, "R1 common zero after reset");

        bus_cycle(0, 1, 1, 26'h2, 1, 16'h1234, 1, 0, "R5 word write");
        bus_cycle(0, 1, 1, 26'h2, 0, 16'h0, 1, 0, "R5 word read");

        bus_cycle(0, 1, 0, 26'h4, 1, 16'h55AB, 1, 0, "R6 even byte write");
        bus_cycle(0, 1, 1, 26'h4, 0, 16'h0, 1, 0, "R8 even byte only");
        bus_cycle(0, 1, 0, 26'h5, 1, 16'h66CD, 1, 0, "R6 odd byte write on low lane");
        bus_cycle(0, 1, 1, 26'h4, 0, 16'h0, 1, 0, "R8 both bytes kept");
        bus_cycle(0, 1, 0, 26'h5, 0, 16'h0, 1, 0, "R6 odd byte read low lane");
        bus_cycle(0, 1, 0, 26'h4, 0, 16'h0, 1, 0, "R6 even byte read low lane");

        bus_cycle(0, 0, 1, 26'h6, 1, 16'hEF11, 1, 0, "R7 high lane write");
        bus_cycle(0, 0, 1, 26'h6, 0, 16'h0, 1, 0, "R7 high lane read");
        bus_cycle(0, 1, 1, 26'h6, 0, 16'h0, 1, 0, "R8 low byte kept on high write");

        bus_cycle(1, 1, 1, 26'h4, 1, 16'h0BAD, 1, 0, "R4 attribute write");
        bus_cycle(0, 1, 1, 26'h4, 1, 16'h2222, 1, 0, "R4 common write");
        bus_cycle(2, 1, 1, 26'h4, 1, 16'h3333, 1, 0, "R4 io write");
        bus_cycle(1, 1, 1, 26'h4, 0, 16'h0, 1, 0, "R4 attribute read");
        bus_cycle(2, 1, 1, 26'h4, 0, 16'h0, 1, 0, "R4 io read");
        bus_cycle(3, 1, 1, 26'h4, 1, 16'h7777, 0, 0, "R4 io strobe with reg high");
        bus_cycle(2, 1, 1, 26'h4, 0, 16'h0, 1, 0, "R4 io unchanged after ignored strobe");

        bus_cycle(0, 0, 0, 26'h4, 1, 16'h9999, 0, 0, "R2 write without enables");
        bus_cycle(0, 1, 1, 26'h4, 0, 16'h0, 1, 0, "R2 common unchanged");

        bus_cycle(0, 1, 1, 26'h2000014, 1, 16'hA1A1, 1, 0, "R9 aliased write");
        bus_cycle(0, 1, 1, 26'h4, 0, 16'h0, 1, 0, "R9 aliased read");

        bus_cycle(0, 1, 1, 26'h4, 0, 16'hDEAD, 1, 1, "R12 read with late write strobe");
        bus_cycle(0, 1, 1, 26'h4, 0, 16'h0, 1, 0, "R12 no second access");

        @(negedge clk);
        card_reset = 1'b1;
        repeat (4) @(negedge clk);
        card_reset = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) m_att[i] = 16'hA500 | 16'(i);
        bus_cycle(1, 1, 1, 26'h4, 0, 16'h0, 1, 0, "R11 attribute back to default");
        bus_cycle(0, 1, 1, 26'h4, 0, 16'h0, 1, 0, "R11 common kept");

        done = 1'b1;
        cmp_en = 1'b0;
        summary();
        $finish;
    end
endmodule